// File: doc/BRIEF.md
# Branch History Predictor and Flush Controller

This block sits beside the fetch stage of a five-stage in-order pipeline. It keeps a small table of per-branch history entries, selected by low bits of the program counter. It returns a combinational taken/not-taken guess for the address being fetched. When a branch later resolves, the pipeline hands back the branch address, the guess that travelled with it and the real outcome. The block then trains the history entry. On a wrong guess it squashes the younger instructions by replacing them with a no-op word, and it tells fetch where to restart.

Two parameters select the variant. `HIST_MODE` picks a one-bit last-outcome history or a two-bit saturating counter. `RESOLVE_EX` says whether branches resolve in execute or in decode. Resolving in execute leaves two younger instructions, in the fetch and decode slots, to kill. Resolving in decode leaves only the one in the fetch slot. Target-address arithmetic and instruction storage live elsewhere. For a wrong taken guess, the block supplies only the fall-through address.

Top module: `bp_flush_unit`

## Requirements
- R1: After reset every table entry predicts not taken: `pred_taken_o` is 0 for every fetch address. In two-bit mode the entries start at counter value 1, in one-bit mode at 0.
- R2: A resolving branch whose outcome matches its carried guess raises no flush and no redirect, and passes both instruction slots through unchanged.
- R3: On a mismatch, `flush_if_o` is raised in the resolving cycle. `flush_id_o` is also raised when `RESOLVE_EX`=1 and stays 0 when `RESOLVE_EX`=0.
- R4: A flushed slot's outgoing instruction equals `NOP_WORD` (default 32'h0000_0000). An unflushed slot passes its input word unchanged.
- R5: When the guess was taken but the branch falls through, `redirect_fallthru_o` is 1 and `redirect_pc_o` equals `res_pc_i`+4.
- R6: `redirect_o` is 1 in exactly the cycles where a valid resolving branch mismatches its guess. When the real outcome is taken, `redirect_fallthru_o` is 0.
- R7: In one-bit mode the entry stores the last resolved outcome, and the next guess for that index equals it.
- R8: In two-bit mode an entry is a counter saturating at 0 and 3. It is incremented on taken and decremented on not taken, and it predicts taken when its value is 2 or 3. From value 3 the guess turns only after two not-taken outcomes in a row.
- R9: The table index is PC bits [5:2]. Addresses that differ only outside those bits share an entry, and other entries are untouched by an update.
- R10: `fetch_en_o` is `!fetch_hold_i` except during a redirect, when it is 1 even with the hold raised.
- R11: The history write happens at the clock edge ending the resolving cycle. A fetch of the same index in the following cycle sees the new guess.
- R12: A correctly guessed taken branch raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Address being fetched |
| fetch_hold_i | input | 1 | Fetch stall request from the pipeline |
| pred_taken_o | output | 1 | Guess for the fetched address |
| fetch_en_o | output | 1 | Fetch may advance this cycle |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | PC_W | Address of the resolving branch |
| res_pred_i | input | 1 | Guess that was made for it at fetch |
| res_taken_i | input | 1 | Real outcome |
| if_instr_i | input | INSTR_W | Word held in the fetch slot |
| id_instr_i | input | INSTR_W | Word held in the decode slot |
| if_instr_o | output | INSTR_W | Fetch slot word after squash |
| id_instr_o | output | INSTR_W | Decode slot word after squash |
| flush_if_o | output | 1 | Fetch slot is squashed |
| flush_id_o | output | 1 | Decode slot is squashed |
| redirect_o | output | 1 | Wrong guess, restart fetch |
| redirect_fallthru_o | output | 1 | Restart at the fall-through address |
| redirect_pc_o | output | PC_W | Fall-through address of the resolving branch |

## Verification
The properties assume that `res_pred_i` and `res_taken_i` are meaningful only while `res_valid_i` is high. They also assume the fetch address is stable across each sampled cycle. The one-bit follow property assumes that a fetch of a just-trained index in the next cycle has no second resolution racing it. The bench takes every carried guess from its own history model, so the guesses match what the table would have produced, and it changes inputs only on the falling edge. Two instances run side by side: a two-bit table resolving in execute and a one-bit table resolving in decode. A directed pass covers saturation, aliasing and hold-versus-flush, and a random pass covers the rest.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    HIST_1BIT = 1'b0,
    HIST_2BIT = 1'b1
  } hist_mode_e;
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table
  import bp_pkg::*;
#(
  parameter int         IDX_W     = 4,
  parameter hist_mode_e HIST_MODE = HIST_2BIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int N     = 1 << IDX_W;
  localparam int CNT_W = (HIST_MODE == HIST_2BIT) ? 2 : 1;
  localparam logic [CNT_W-1:0] RST_VAL = (HIST_MODE == HIST_2BIT) ? CNT_W'(1) : '0;

  logic [N-1:0][CNT_W-1:0] ent_q;
  logic [CNT_W-1:0]        cur, nxt;

  assign cur        = ent_q[wr_idx_i];
  assign rd_taken_o = ent_q[rd_idx_i][CNT_W-1];

  generate
    if (HIST_MODE == HIST_2BIT) begin : g_sat
      always_comb begin
        if (wr_taken_i) nxt = (cur == '1) ? cur : cur + CNT_W'(1);
        else            nxt = (cur == '0) ? cur : cur - CNT_W'(1);
      end
    end else begin : g_last
      always_comb nxt = CNT_W'(wr_taken_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ent_q <= {N{RST_VAL}};
    else if (wr_en_i) ent_q[wr_idx_i] <= nxt;
  end
endmodule

// File: rtl/bp_flush_ctl.sv
module bp_flush_ctl #(
  parameter int PC_W       = 32,
  parameter bit RESOLVE_EX = 1'b1
) (
  input  logic            res_valid_i,
  input  logic            res_pred_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            fetch_hold_i,
  output logic            flush_if_o,
  output logic            flush_id_o,
  output logic            redirect_o,
  output logic            redirect_fallthru_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            fetch_en_o
);
  logic mispred;

  assign mispred             = res_valid_i & (res_pred_i ^ res_taken_i);
  assign redirect_o          = mispred;
  assign redirect_fallthru_o = mispred & ~res_taken_i;
  assign redirect_pc_o       = res_pc_i + PC_W'(4);
  assign flush_if_o          = mispred;
  // flush beats hold so the restart address is taken
  assign fetch_en_o          = ~fetch_hold_i | mispred;

  generate
    if (RESOLVE_EX) begin : g_ex
      assign flush_id_o = mispred;
    end else begin : g_id
      assign flush_id_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bp_squash.sv
module bp_squash #(
  parameter int               W   = 32,
  parameter logic [W-1:0]     NOP = '0
) (
  input  logic [W-1:0] instr_i,
  input  logic         kill_i,
  output logic [W-1:0] instr_o
);
  assign instr_o = kill_i ? NOP : instr_i;
endmodule

// File: rtl/bp_flush_unit.sv
module bp_flush_unit
  import bp_pkg::*;
#(
  parameter int               PC_W       = 32,
  parameter int               INSTR_W    = 32,
  parameter int               IDX_W      = 4,
  parameter int               IDX_LSB    = 2,
  parameter hist_mode_e       HIST_MODE  = HIST_2BIT,
  parameter bit               RESOLVE_EX = 1'b1,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    fetch_pc_i,
  input  logic               fetch_hold_i,
  output logic               pred_taken_o,
  output logic               fetch_en_o,
  input  logic               res_valid_i,
  input  logic [PC_W-1:0]    res_pc_i,
  input  logic               res_pred_i,
  input  logic               res_taken_i,
  input  logic [INSTR_W-1:0] if_instr_i,
  input  logic [INSTR_W-1:0] id_instr_i,
  output logic [INSTR_W-1:0] if_instr_o,
  output logic [INSTR_W-1:0] id_instr_o,
  output logic               flush_if_o,
  output logic               flush_id_o,
  output logic               redirect_o,
  output logic               redirect_fallthru_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  logic unused_fetch_pc;
  assign unused_fetch_pc = ^{fetch_pc_i[PC_W-1:IDX_LSB+IDX_W], fetch_pc_i[IDX_LSB-1:0]};

  bp_hist_table #(.IDX_W(IDX_W), .HIST_MODE(HIST_MODE)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_pc_i[IDX_LSB +: IDX_W]),
    .rd_taken_o (pred_taken_o),
    .wr_en_i    (res_valid_i),
    .wr_idx_i   (res_pc_i[IDX_LSB +: IDX_W]),
    .wr_taken_i (res_taken_i)
  );

  bp_flush_ctl #(.PC_W(PC_W), .RESOLVE_EX(RESOLVE_EX)) u_ctl (
    .res_valid_i         (res_valid_i),
    .res_pred_i          (res_pred_i),
    .res_taken_i         (res_taken_i),
    .res_pc_i            (res_pc_i),
    .fetch_hold_i        (fetch_hold_i),
    .flush_if_o          (flush_if_o),
    .flush_id_o          (flush_id_o),
    .redirect_o          (redirect_o),
    .redirect_fallthru_o (redirect_fallthru_o),
    .redirect_pc_o       (redirect_pc_o),
    .fetch_en_o          (fetch_en_o)
  );

  bp_squash #(.W(INSTR_W), .NOP(NOP_WORD)) u_sq_if (
    .instr_i (if_instr_i),
    .kill_i  (flush_if_o),
    .instr_o (if_instr_o)
  );

  bp_squash #(.W(INSTR_W), .NOP(NOP_WORD)) u_sq_id (
    .instr_i (id_instr_i),
    .kill_i  (flush_id_o),
    .instr_o (id_instr_o)
  );
endmodule

// File: rtl/bp_flush_unit_chk.sv
module bp_flush_unit_chk
  import bp_pkg::*;
#(
  parameter int                 PC_W      = 32,
  parameter int                 INSTR_W   = 32,
  parameter int                 IDX_W     = 4,
  parameter int                 IDX_LSB   = 2,
  parameter hist_mode_e         HIST_MODE = HIST_2BIT,
  parameter logic [INSTR_W-1:0] NOP_WORD  = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PC_W-1:0]    fetch_pc_i,
  input logic               pred_taken_o,
  input logic               fetch_en_o,
  input logic               res_valid_i,
  input logic [PC_W-1:0]    res_pc_i,
  input logic               res_pred_i,
  input logic               res_taken_i,
  input logic [INSTR_W-1:0] if_instr_o,
  input logic               flush_if_o,
  input logic               flush_id_o,
  input logic               redirect_o,
  input logic               redirect_fallthru_o,
  input logic [PC_W-1:0]    redirect_pc_o
);
  // R3
  id_implies_if_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_id_o |-> flush_if_o);
  // R2
  no_flush_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && (res_pred_i == res_taken_i)) |-> (!flush_if_o && !redirect_o));
  // R4
  nop_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_if_o |-> (if_instr_o == NOP_WORD));
  // R5
  fallthru_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_fallthru_o |-> (redirect_o && redirect_pc_o == res_pc_i + PC_W'(4)));
  // R6
  redirect_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && (res_pred_i != res_taken_i)) |-> redirect_o);
  // R10
  flush_over_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> fetch_en_o);

  generate
    if (HIST_MODE == HIST_1BIT) begin : g_one
      // R7
      hist1_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_i |=> ((fetch_pc_i[IDX_LSB +: IDX_W] != $past(res_pc_i[IDX_LSB +: IDX_W]))
                         || (pred_taken_o == $past(res_taken_i))));
    end
  endgenerate
endmodule

bind bp_flush_unit bp_flush_unit_chk #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
  .HIST_MODE(HIST_MODE), .NOP_WORD(NOP_WORD)
) u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .fetch_pc_i          (fetch_pc_i),
  .pred_taken_o        (pred_taken_o),
  .fetch_en_o          (fetch_en_o),
  .res_valid_i         (res_valid_i),
  .res_pc_i            (res_pc_i),
  .res_pred_i          (res_pred_i),
  .res_taken_i         (res_taken_i),
  .if_instr_o          (if_instr_o),
  .flush_if_o          (flush_if_o),
  .flush_id_o          (flush_id_o),
  .redirect_o          (redirect_o),
  .redirect_fallthru_o (redirect_fallthru_o),
  .redirect_pc_o       (redirect_pc_o)
);

// File: tb/bp_flush_unit_tb.sv
module bp_flush_unit_tb;
  import bp_pkg::*;

  localparam logic [31:0] NOP = 32'h0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc = '0, rpc = '0, ifi = '0, idi = '0;
  logic hold = 1'b0, rv = 1'b0, rt = 1'b0, rp2 = 1'b0, rp1 = 1'b0;

  logic pred2, fen2, fif2, fid2, rd2, rf2;
  logic pred1, fen1, fif1, fid1, rd1, rf1;
  logic [31:0] ifo2, ido2, rpo2, ifo1, ido1, rpo1;

  int ref2 [16];
  int ref1 [16];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bp_flush_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(pc), .fetch_hold_i(hold),
    .pred_taken_o(pred2), .fetch_en_o(fen2), .res_valid_i(rv), .res_pc_i(rpc),
    .res_pred_i(rp2), .res_taken_i(rt), .if_instr_i(ifi), .id_instr_i(idi),
    .if_instr_o(ifo2), .id_instr_o(ido2), .flush_if_o(fif2), .flush_id_o(fid2),
    .redirect_o(rd2), .redirect_fallthru_o(rf2), .redirect_pc_o(rpo2)
  );

  bp_flush_unit #(.HIST_MODE(HIST_1BIT), .RESOLVE_EX(1'b0)) u_dut_id (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(pc), .fetch_hold_i(hold),
    .pred_taken_o(pred1), .fetch_en_o(fen1), .res_valid_i(rv), .res_pc_i(rpc),
    .res_pred_i(rp1), .res_taken_i(rt), .if_instr_i(ifi), .id_instr_i(idi),
    .if_instr_o(ifo1), .id_instr_o(ido1), .flush_if_o(fif1), .flush_id_o(fid1),
    .redirect_o(rd1), .redirect_fallthru_o(rf1), .redirect_pc_o(rpo1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [31:0] fpc, input logic v, input logic [31:0] bpc,
                       input logic tk, input logic hd, input logic [31:0] wi, input logic [31:0] wd);
    @(negedge clk);
    pc = fpc; rv = v; rpc = bpc; rt = tk; hold = hd; ifi = wi; idi = wd;
    rp2 = (ref2[bpc[5:2]] >= 2);
    rp1 = (ref1[bpc[5:2]] == 1);
    #1;
  endtask

  task automatic finish_cyc();
    logic m2, m1;
    int i;
    m2 = rv && (rp2 != rt);
    m1 = rv && (rp1 != rt);
    i  = int'(pc[5:2]);
    chk("R8", 32'(pred2), 32'(ref2[i] >= 2));
    chk("R7", 32'(pred1), 32'(ref1[i] == 1));
    chk("R3", 32'(fif2), 32'(m2));
    chk("R3", 32'(fid2), 32'(m2));
    chk("R3", 32'(fif1), 32'(m1));
    chk("R3", 32'(fid1), 32'(0));
    chk("R4", ifo2, m2 ? NOP : ifi);
    chk("R4", ido2, m2 ? NOP : idi);
    chk("R4", ifo1, m1 ? NOP : ifi);
    chk("R4", ido1, idi);
    chk("R6", 32'(rd2), 32'(m2));
    chk("R6", 32'(rd1), 32'(m1));
    chk("R5", 32'(rf2), 32'(m2 && !rt));
    chk("R5", 32'(rf1), 32'(m1 && !rt));
    if (m2 && !rt) chk("R5", rpo2, rpc + 32'd4);
    if (m1 && !rt) chk("R5", rpo1, rpc + 32'd4);
    chk("R10", 32'(fen2), 32'(!hold || m2));
    chk("R10", 32'(fen1), 32'(!hold || m1));
    @(posedge clk);
    if (rv) begin
      int j;
      j = int'(rpc[5:2]);
      ref1[j] = rt ? 1 : 0;
      if (rt) ref2[j] = (ref2[j] == 3) ? 3 : ref2[j] + 1;
      else    ref2[j] = (ref2[j] == 0) ? 0 : ref2[j] - 1;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) begin ref2[e] = 1; ref1[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every index predicts not taken after reset
    for (int e = 0; e < 16; e++) begin
      drive(32'(e * 4), 1'b0, '0, 1'b0, 1'b0, 32'h11, 32'h22);
      chk("R1", 32'(pred2), 32'(0));
      chk("R1", 32'(pred1), 32'(0));
      finish_cyc();
    end

    // taken while hold raised: both mispredict, flush wins over hold
    drive(32'h0C, 1'b1, 32'h0C, 1'b1, 1'b1, 32'hAAAA_0001, 32'hBBBB_0002);
    chk("R6", 32'(rd2), 32'(1));
    chk("R6", 32'(rf2), 32'(0));
    chk("R10", 32'(fen2), 32'(1));
    chk("R3", 32'(fid2), 32'(1));
    chk("R3", 32'(fid1), 32'(0));
    chk("R4", ido1, 32'hBBBB_0002);
    finish_cyc();
    // R11: new history visible the next cycle
    drive(32'h0C, 1'b0, '0, 1'b0, 1'b0, 32'h1, 32'h2);
    chk("R11", 32'(pred1), 32'(1));
    chk("R11", 32'(pred2), 32'(1));
    finish_cyc();
    // correctly guessed taken, counter saturates at 3
    repeat (2) begin
      drive(32'h0C, 1'b1, 32'h0C, 1'b1, 1'b0, 32'h3, 32'h4);
      chk("R12", 32'(fif2), 32'(0));
      chk("R12", 32'(fif1), 32'(0));
      finish_cyc();
    end
    // R9: aliasing through bits above the index, neighbours untouched
    drive(32'h4C, 1'b0, '0, 1'b0, 1'b0, 32'h5, 32'h6);
    chk("R9", 32'(pred2), 32'(1));
    finish_cyc();
    drive(32'h10, 1'b0, '0, 1'b0, 1'b0, 32'h5, 32'h6);
    chk("R9", 32'(pred2), 32'(0));
    finish_cyc();
    // first not-taken from strong taken: fall-through redirect, guess holds
    drive(32'h0C, 1'b1, 32'h0C, 1'b0, 1'b0, 32'h7, 32'h8);
    chk("R5", 32'(rf2), 32'(1));
    chk("R5", rpo2, 32'h10);
    finish_cyc();
    drive(32'h0C, 1'b0, '0, 1'b0, 1'b0, 32'h9, 32'hA);
    chk("R8", 32'(pred2), 32'(1));
    chk("R7", 32'(pred1), 32'(0));
    finish_cyc();
    drive(32'h0C, 1'b1, 32'h0C, 1'b0, 1'b0, 32'h9, 32'hA);
    finish_cyc();
    drive(32'h0C, 1'b0, '0, 1'b0, 1'b0, 32'h9, 32'hA);
    chk("R8", 32'(pred2), 32'(0));
    finish_cyc();
    // R2: correct not-taken guess
    drive(32'h14, 1'b1, 32'h14, 1'b0, 1'b1, 32'hC, 32'hD);
    chk("R2", 32'(fif2), 32'(0));
    chk("R2", 32'(rd2), 32'(0));
    chk("R2", ifo2, 32'hC);
    chk("R10", 32'(fen2), 32'(0));
    finish_cyc();

    // random traffic
    for (int k = 0; k < 600; k++) begin
      drive({24'h0, 8'($urandom) & 8'hFC}, 1'($urandom), {24'h0, 8'($urandom) & 8'hFC},
            1'($urandom), (($urandom % 4) == 0), $urandom, $urandom);
      finish_cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule